// File: doc/BRIEF.md
# Cascaded rotating-priority PCI sub-arbiter

This block lets three bus masters share one request/grant pair on a central bus arbiter. Each downstream master has its own active-low request and grant. The block merges the requests into a single active-low upstream request. It passes a grant down to exactly one master, and only while the central arbiter holds the upstream grant.

The downstream winner is chosen by rotating priority. When an owner lets go of the bus, the master after it becomes the first in line. An owner also loses its turn when a target stops its transfer: this is seen as FRAME# and STOP# both asserted at a rising clock edge. FRAME# may be left unconnected and then reads as deasserted. In that case rotation happens only when a request is released.

A grant never moves straight from one master to another. At least one full clock period with no downstream grant lies between them. While reset is held, or while the clock-active input is low (power-down), every grant and the upstream request are held deasserted.

Top module: `pci_cascade_arb`

## Requirements
- R1: `upReqN` is low in the same cycle as any bit of `reqN` is low, with no clock of delay, unless the block is in reset or power-down.
- R2: A bit of `gntN` is low only while `upGntN` is low, and at most one bit of `gntN` is low at a time. When the upstream grant arrives for an already selected master, that master's grant appears in the same cycle.
- R3: Bit i of `reqN`/`gntN` belongs to master i (0, 1, 2). After master i releases, the search for the next owner starts at master i+1, wrapping from 2 to 0. It does not start from a fixed master.
- R4: When the grant moves from one master to a different one, at least one clock edge with all of `gntN` high lies between the two grants.
- R5: An owner keeps its grant for as long as its request and the upstream grant stay low and no fairness rotation occurs.
- R6: When the owner's request is sampled high at a rising edge while it is granted, its grant is high from that edge on.
- R7: When `frameN` and `stopN` are both sampled low at a rising edge during a grant, the owner loses the grant at that edge. The search then starts at the master after it.
- R8: With `frameN` high, a low `stopN` has no effect on the current grant.
- R9: If `upGntN` goes high, all grants go high. When the upstream grant returns, arbitration resumes from the saved rotation start, so the same master gets the grant back.
- R10: A master whose request was not low at the preceding rising edge is never given a new grant, and with no request low no grant is driven.
- R11: While `rstN` is low, all of `gntN` and `upReqN` are high. After reset, the search starts at master 0.
- R12: While `clkActive` is low, all of `gntN` and `upReqN` are high, and ownership is dropped. The rotation start is kept across power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkActive | input | 1 | High while the input clock runs; low enters power-down |
| reqN | input | 3 | Downstream requests, active low, bit i = master i |
| gntN | output | 3 | Downstream grants, active low, bit i = master i |
| upReqN | output | 1 | Merged request to the central arbiter, active low |
| upGntN | input | 1 | Grant from the central arbiter, active low |
| frameN | input | 1 | Bus FRAME#, active low; reads high when unconnected |
| stopN | input | 1 | Bus STOP#, active low |

## Verification
Two requests are raised together while a third master owns the bus, and the owner is then released. The next grant going to the master after the old owner, and not to master 0, tells rotating priority apart from fixed priority. Holding STOP# low with FRAME# first high and then low separates the ignored case from a fairness rotation. The grant that follows shows the pointer moved on. Removing and restoring the upstream grant, a power-down and a mid-run reset are each followed by a two-master request pattern. That pattern shows whether the rotation start was kept, kept or reset to master 0, as each requirement says.

// File: rtl/pci_cascade_arb_pkg.sv
package pci_cascade_arb_pkg;

  // Strobes from the control into the ownership datapath.
  typedef struct packed {
    logic pickEn;   // load a new owner from the rotating search
    logic dropEn;   // give up ownership and move the start past the owner
    logic sleepEn;  // power-down: drop ownership, keep the start pointer
  } arbStrobeT;

endpackage

// File: rtl/pci_cascade_arb_ctrl.sv
module pci_cascade_arb_ctrl
  import pci_cascade_arb_pkg::*;
(
  input  logic      clkActive,
  input  logic      upGntN,
  input  logic      frameN,
  input  logic      stopN,
  input  logic      ownValid,
  input  logic      ownerReq,
  output arbStrobeT strobe
);

  logic upHeld;
  logic fairHit;

  always_comb begin
    upHeld  = !upGntN;
    // A target stopping the current owner's transfer costs it its turn.
    fairHit = !frameN && !stopN;

    strobe.sleepEn = !clkActive;
    // Without the upstream grant nothing is driven, so re-picking is free;
    // with it, only an empty slot (the dead cycle after a drop) is refilled.
    strobe.pickEn  = clkActive && (!upHeld || !ownValid);
    strobe.dropEn  = clkActive && upHeld && ownValid && (!ownerReq || fairHit);
  end

endmodule

// File: rtl/pci_cascade_arb_dp.sv
module pci_cascade_arb_dp
  import pci_cascade_arb_pkg::*;
#(
  parameter int NUM_MASTERS = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   clkActive,
  input  logic [NUM_MASTERS-1:0] reqN,
  input  logic                   upGntN,
  input  arbStrobeT              strobe,
  output logic                   ownValid,
  output logic                   ownerReq,
  output logic [NUM_MASTERS-1:0] gntN,
  output logic                   upReqN
);

  localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_MASTERS - 1);

  logic [IDX_W-1:0]       startPtr;
  logic [IDX_W-1:0]       ownIdx;
  logic [IDX_W-1:0]       pickIdx;
  logic                   pickValid;
  logic [NUM_MASTERS-1:0] ownMask;
  logic [NUM_MASTERS-1:0] reqActive;
  logic                   live;

  assign reqActive = ~reqN;
  assign live      = rstN && clkActive;

  // Rotating search: the lowest offset from startPtr that requests wins.
  always_comb begin
    pickValid = 1'b0;
    pickIdx   = startPtr;
    for (int off = NUM_MASTERS - 1; off >= 0; off--) begin
      int cand;
      cand = int'(startPtr) + off;
      if (cand >= NUM_MASTERS) cand = cand - NUM_MASTERS;
      if (reqActive[cand]) begin
        pickValid = 1'b1;
        pickIdx   = IDX_W'(cand);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPtr <= '0;
      ownIdx   <= '0;
      ownValid <= 1'b0;
    end else if (strobe.sleepEn) begin
      ownValid <= 1'b0;
    end else if (strobe.dropEn) begin
      ownValid <= 1'b0;
      startPtr <= (ownIdx == LAST_IDX) ? '0 : ownIdx + 1'b1;
    end else if (strobe.pickEn) begin
      ownValid <= pickValid;
      ownIdx   <= pickIdx;
    end
  end

  // One-hot owner decode, gated to form the grants without extra latency.
  for (genvar g = 0; g < NUM_MASTERS; g++) begin : gen_grant
    assign ownMask[g] = ownValid && (ownIdx == IDX_W'(g));
    assign gntN[g]    = !(live && !upGntN && ownMask[g]);
  end

  assign ownerReq = |(reqActive & ownMask);
  assign upReqN   = !(live && |reqActive);

endmodule

// File: rtl/pci_cascade_arb.sv
module pci_cascade_arb
  import pci_cascade_arb_pkg::*;
#(
  parameter int NUM_MASTERS = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   clkActive,
  input  logic [NUM_MASTERS-1:0] reqN,
  output logic [NUM_MASTERS-1:0] gntN,
  output logic                   upReqN,
  input  logic                   upGntN,
  input  logic                   frameN,
  input  logic                   stopN
);

  arbStrobeT strobe;
  logic      ownValid;
  logic      ownerReq;

  pci_cascade_arb_ctrl u_ctrl (
    .clkActive (clkActive),
    .upGntN    (upGntN),
    .frameN    (frameN),
    .stopN     (stopN),
    .ownValid  (ownValid),
    .ownerReq  (ownerReq),
    .strobe    (strobe)
  );

  pci_cascade_arb_dp #(.NUM_MASTERS(NUM_MASTERS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .clkActive (clkActive),
    .reqN      (reqN),
    .upGntN    (upGntN),
    .strobe    (strobe),
    .ownValid  (ownValid),
    .ownerReq  (ownerReq),
    .gntN      (gntN),
    .upReqN    (upReqN)
  );

endmodule

// File: rtl/pci_cascade_arb_chk.sv
module pci_cascade_arb_chk #(
  parameter int NUM_MASTERS = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   clkActive,
  input logic [NUM_MASTERS-1:0] reqN,
  input logic [NUM_MASTERS-1:0] gntN,
  input logic                   upReqN,
  input logic                   upGntN,
  input logic                   frameN,
  input logic                   stopN
);

  always_comb begin
    if (!rstN) begin
      assert_reset_quiet_R11: assert (&gntN && upReqN);
    end
    if (clkActive == 1'b0) begin
      assert_sleep_quiet_R12: assert (&gntN && upReqN);
    end
  end

  assert_upreq_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((~reqN != '0) && clkActive) |-> !upReqN);

  assert_grant_needs_upstream_R2: assert property (@(posedge clk) disable iff (!rstN)
    (~gntN != '0) |-> !upGntN);

  assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~gntN));

  assert_dead_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (($past(~gntN) != '0) && (~gntN != '0)) |-> (gntN == $past(gntN)));

  assert_stop_rotates_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!frameN && !stopN && (~gntN != '0)) |=> (&gntN));

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : gen_per_master
    assert_release_drops_R6: assert property (@(posedge clk) disable iff (!rstN)
      (!gntN[m] && reqN[m]) |=> gntN[m]);

    assert_no_parking_R10: assert property (@(posedge clk) disable iff (!rstN)
      $fell(gntN[m]) |-> !$past(reqN[m]));
  end

endmodule

bind pci_cascade_arb pci_cascade_arb_chk #(.NUM_MASTERS(NUM_MASTERS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .clkActive (clkActive),
  .reqN      (reqN),
  .gntN      (gntN),
  .upReqN    (upReqN),
  .upGntN    (upGntN),
  .frameN    (frameN),
  .stopN     (stopN)
);

// File: tb/test_pci_cascade_arb.sv
module test_pci_cascade_arb;

  localparam logic [2:0] G_NONE = 3'b111;
  localparam logic [2:0] G_M0   = 3'b110;
  localparam logic [2:0] G_M1   = 3'b101;
  localparam logic [2:0] G_M2   = 3'b011;

  logic       clk = 1'b0;
  logic       rstN;
  logic       clkActive;
  logic [2:0] reqN;
  logic [2:0] gntN;
  logic       upReqN;
  logic       upGntN;
  logic       frameN;
  logic       stopN;

  int  checks = 0;
  int  fails  = 0;
  int  cycles = 0;
  bit  done   = 1'b0;

  pci_cascade_arb i_pci_cascade_arb (
    .clk       (clk),
    .rstN      (rstN),
    .clkActive (clkActive),
    .reqN      (reqN),
    .gntN      (gntN),
    .upReqN    (upReqN),
    .upGntN    (upGntN),
    .frameN    (frameN),
    .stopN     (stopN)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  // Advance to 5 ns after the next rising edge.
  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic expect_out(string tag, logic [2:0] expG, logic expUp);
    checks++;
    if (gntN !== expG || upReqN !== expUp) begin
      fails++;
      $display("FAIL %s: gntN=%b upReqN=%b expected gntN=%b upReqN=%b",
               tag, gntN, upReqN, expG, expUp);
    end
  endtask

  task automatic test_reset_hold();
    rstN = 1'b0; reqN = 3'b000; upGntN = 1'b0;
    step(); settle();
    expect_out("R11 outputs quiet in reset", G_NONE, 1'b1);
    reqN = 3'b111; upGntN = 1'b1;
    step();
    rstN = 1'b1;
    step(); settle();
    expect_out("R11 idle after reset", G_NONE, 1'b1);
  endtask

  task automatic test_upreq_path();
    reqN = 3'b011; settle();
    expect_out("R1 upReq same cycle, no grant without upstream (R2)", G_NONE, 1'b0);
    reqN = 3'b111; settle();
    expect_out("R1 upReq drops with request", G_NONE, 1'b1);
  endtask

  task automatic test_rotation();
    reqN = 3'b001;             // masters 1 and 2
    step(); settle();
    expect_out("R2 selected but no upstream grant", G_NONE, 1'b0);
    upGntN = 1'b0; settle();
    expect_out("R2 grant follows upstream with no latency", G_M1, 1'b0);
    step(); settle();
    expect_out("R5 owner holds", G_M1, 1'b0);
    reqN = 3'b000;             // master 0 joins
    step(); settle();
    expect_out("R5 owner holds despite new request", G_M1, 1'b0);
    reqN = 3'b010;             // master 1 releases, 0 and 2 wait
    step(); settle();
    expect_out("R6 R4 dead cycle after release", G_NONE, 1'b0);
    step(); settle();
    expect_out("R3 next after master 1 is master 2", G_M2, 1'b0);
    reqN = 3'b110;             // only master 0 left
    step(); settle();
    expect_out("R4 dead cycle before master 0", G_NONE, 1'b0);
    step(); settle();
    expect_out("R3 wrap to master 0", G_M0, 1'b0);
    reqN = 3'b111;
    step(); settle();
    expect_out("R6 release with no other request", G_NONE, 1'b1);
    step(); settle();
    expect_out("R10 no parking when idle", G_NONE, 1'b1);
  endtask

  task automatic test_fairness();
    reqN = 3'b001;             // start pointer now at master 1
    step(); settle();
    expect_out("R3 pick from master 1", G_M1, 1'b0);
    stopN = 1'b0;              // FRAME# left high
    step(); settle();
    expect_out("R8 STOP ignored without FRAME", G_M1, 1'b0);
    step(); settle();
    expect_out("R8 STOP still ignored", G_M1, 1'b0);
    frameN = 1'b0;
    step(); settle();
    expect_out("R7 stop during frame drops owner", G_NONE, 1'b0);
    frameN = 1'b1; stopN = 1'b1;
    step(); settle();
    expect_out("R7 rotation moves to master 2", G_M2, 1'b0);
    reqN = 3'b111;
    step(); settle();
    expect_out("R6 master 2 releases", G_NONE, 1'b1);
  endtask

  task automatic test_upstream_loss();
    reqN = 3'b100;             // masters 0 and 1, start pointer at 0
    step(); settle();
    expect_out("R3 pick master 0", G_M0, 1'b0);
    upGntN = 1'b1; settle();
    expect_out("R9 grants fall with upstream grant", G_NONE, 1'b0);
    step(); settle();
    expect_out("R9 nothing driven without upstream", G_NONE, 1'b0);
    upGntN = 1'b0; settle();
    expect_out("R9 resumes at saved pointer (master 0)", G_M0, 1'b0);
    reqN = 3'b111;
    step(); settle();
    expect_out("R6 release after resume", G_NONE, 1'b1);
  endtask

  task automatic test_power_down();
    reqN = 3'b010;             // masters 0 and 2, start pointer at 1
    step(); settle();
    expect_out("R3 pick master 2 from pointer 1", G_M2, 1'b0);
    clkActive = 1'b0; settle();
    expect_out("R12 power-down silences outputs", G_NONE, 1'b1);
    step(); settle();
    expect_out("R12 still silent", G_NONE, 1'b1);
    clkActive = 1'b1; settle();
    expect_out("R12 ownership dropped", G_NONE, 1'b0);
    step(); settle();
    expect_out("R12 pointer kept across power-down", G_M2, 1'b0);
  endtask

  task automatic test_reset_mid_run();
    rstN = 1'b0; settle();
    expect_out("R11 reset during grant", G_NONE, 1'b1);
    step();
    rstN = 1'b1;
    step(); settle();
    expect_out("R11 pointer back to master 0", G_M0, 1'b0);
    reqN = 3'b111;
    step();
  endtask

  initial begin
    rstN = 1'b0; clkActive = 1'b1; reqN = 3'b111;
    upGntN = 1'b1; frameN = 1'b1; stopN = 1'b1;
    test_reset_hold();
    test_upreq_path();
    test_rotation();
    test_fairness();
    test_upstream_loss();
    test_power_down();
    test_reset_mid_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule